// File: doc/BRIEF.md
# NAND Command Stream to Sequencer Microprogram Translator

This block sits between software-style NAND access calls and a hardware opcode sequencer. Software issues a flat stream of requests: a command byte, an address byte, a start, or a single buffer byte read or write. The translator turns that stream into the values an opcode sequencer needs: an eight-slot opcode word, a four-slot command word, a byte count, a block address, a page address and a data-register value. On start it hands these over with a one-cycle start pulse.

While a transaction is built, the block counts the command and opcode slots already used. It collects column and row address bytes in the order the command needs. It applies the half-page and spare-area offsets of small-page parts and picks the page-buffer window that later byte accesses use. A status command routes the next byte read to the sequencer's data register instead of the buffer. Only one chip select is served. The page geometry (large or small) and the number of row address bytes are static configuration inputs.

Top module: `nand_uprog_xlate`

## Requirements
- R1: The first command byte of a transaction takes opcode 0xC (wait, then issue command slot 0). Command byte n (n>0) takes opcode 4+n. Opcode slot k sits in seq_instr bits [31-4k -: 4], and command slot n sits in seq_cmd bits [31-8n -: 8].
- R2: The program-confirm command (0x10) first places a write-buffer opcode 0x8 in the next opcode slot, and then its own command opcode.
- R3: After read-ID (0x90), one address byte adds user-address opcode 0x3. It sets byte count 5, block 0 and page 0, loads the byte into seq_mdr, and sets window base and buffer pointer to 0. Start appends wait-then-read opcode 0xE.
- R4: The status command (0x70) makes start append opcode 0xB. The next byte read returns mdr_in on stat_byte with stat_valid and no buffer access. Later reads use the buffer again.
- R5: Erase (0x60) collects cfg_row_cycles row bytes only. Read (0x00, 0x01, 0x50) and program (0x80) collect column bytes first and then row bytes, each group least significant byte first. There are two column bytes for large pages and one for small pages.
- R6: Small-page command 0x01 adds 256 to the column and 0x50 adds 512.
- R7: When the last address byte arrives, opcode 0x1 is added (column transactions only) and then opcode 0x2. The page address is the column OR the page index: row[5:0] at bits 17:12 for large pages, row[4:0] at bits 14:10 for small pages. A nonzero column sets the byte count to page size minus column and the buffer pointer to the column. A zero column leaves the byte count at 0.
- R8: The block address is row>>6 for large pages and row>>5 for small pages. The window base is (row&1)*4096 for large pages and (row&7)*1024 for small pages.
- R9: A start request pulses seq_start one cycle later and presents the gathered values, with the saved data opcode appended. It then clears all per-command state but keeps the window base, the buffer pointer and the status flag.
- R10: A buffer byte read (kind 3) or write (kind 4) presents buf_addr = base + pointer with buf_strobe one cycle later, and then increments the pointer. With the pointer at or beyond the page size (2112 large, 528 small), it raises err_range instead and the pointer does not move.
- R11: An address byte while no command expects one pulses err_proto and changes nothing.
- R12: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_large | input | 1 | 1 = large-page geometry, 0 = small-page |
| cfg_row_cycles | input | 3 | Number of row address bytes |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | 0 command, 1 address, 2 start, 3 read byte, 4 write byte |
| req_data | input | 8 | Command, address or write byte |
| mdr_in | input | 8 | Sequencer data register, read back for status |
| seq_start | output | 1 | One-cycle sequencer start pulse |
| seq_instr | output | 32 | Eight 4-bit opcode slots, slot 0 in the top nibble |
| seq_cmd | output | 32 | Four command byte slots, slot 0 in the top byte |
| seq_bcount | output | 12 | Byte count |
| seq_block | output | 32 | Block address |
| seq_page | output | 32 | Page and column address |
| seq_mdr | output | 8 | Data register value for the sequencer |
| buf_strobe | output | 1 | Buffer byte access pulse |
| buf_write | output | 1 | The buffer access is a write |
| buf_addr | output | 13 | Buffer byte address |
| buf_wdata | output | 8 | Buffer write byte |
| stat_valid | output | 1 | Status byte returned |
| stat_byte | output | 8 | Returned status byte |
| err_range | output | 1 | Buffer access beyond page size rejected |
| err_proto | output | 1 | Unexpected address byte ignored |

## Verification
The bench uses the default page sizes (2112 and 528) and the default command codes. It switches cfg_large between both geometries and uses three row bytes for large pages and two for small pages. This exercises two-byte and one-byte column gathering, both window base formulas, the half-page and spare offsets, and pointer exhaustion on a 16-byte spare read that runs into err_range. A behavioural model compares every output on every cycle. Directed checks confirm hand-derived opcode words for read-ID, status, read, program and erase.

// File: rtl/nand_uprog_xlate.sv
module nand_uprog_xlate #(
  parameter int LP_BYTES = 2112,
  parameter int SP_BYTES = 528,
  parameter logic [7:0] C_READ   = 8'h00,
  parameter logic [7:0] C_HALF_B = 8'h01,
  parameter logic [7:0] C_SPARE  = 8'h50,
  parameter logic [7:0] C_ID     = 8'h90,
  parameter logic [7:0] C_STAT   = 8'h70,
  parameter logic [7:0] C_ERASE  = 8'h60,
  parameter logic [7:0] C_PROG   = 8'h80,
  parameter logic [7:0] C_PGO    = 8'h10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_large,
  input  logic [2:0]  cfg_row_cycles,
  input  logic        req_valid,
  input  logic [2:0]  req_kind,
  input  logic [7:0]  req_data,
  input  logic [7:0]  mdr_in,
  output logic        seq_start,
  output logic [31:0] seq_instr,
  output logic [31:0] seq_cmd,
  output logic [11:0] seq_bcount,
  output logic [31:0] seq_block,
  output logic [31:0] seq_page,
  output logic [7:0]  seq_mdr,
  output logic        buf_strobe,
  output logic        buf_write,
  output logic [12:0] buf_addr,
  output logic [7:0]  buf_wdata,
  output logic        stat_valid,
  output logic [7:0]  stat_byte,
  output logic        err_range,
  output logic        err_proto
);
  localparam logic [2:0] K_CMD = 3'd0, K_ADR = 3'd1, K_GO = 3'd2, K_RD = 3'd3, K_WR = 3'd4;
  localparam logic [1:0] A_NONE = 2'd0, A_ID = 2'd1, A_ROW = 2'd2, A_RC = 2'd3;
  localparam logic [3:0] OP_CA = 4'h1, OP_PA = 4'h2, OP_UA = 4'h3, OP_WB = 4'h8,
                         OP_RS = 4'hB, OP_CW0 = 4'hC, OP_RBW = 4'hE;
  localparam logic [11:0] LP_SZ = 12'(LP_BYTES);
  localparam logic [11:0] SP_SZ = 12'(SP_BYTES);

  function automatic logic [31:0] put_op(logic [31:0] v, int s, logic [3:0] op);
    logic [31:0] r;
    r = v;
    if (s >= 0 && s < 8) r[(7 - s) * 4 +: 4] = op;
    return r;
  endfunction

  function automatic logic [31:0] put_cmd(logic [31:0] v, int s, logic [7:0] c);
    logic [31:0] r;
    r = v;
    if (s >= 0 && s < 4) r[(3 - s) * 8 +: 8] = c;
    return r;
  endfunction

  logic [31:0] instr_q, instr_d, cmd_q, cmd_d, row_q, row_d, blk_q, blk_d, page_q, page_d;
  logic [15:0] col_q, col_d;
  logic [2:0]  cmdnr_q, cmdnr_d, abytes_q, abytes_d;
  logic [3:0]  opnr_q, opnr_d, dop_q, dop_d;
  logic [9:0]  pgofs_q, pgofs_d;
  logic [1:0]  atype_q, atype_d;
  logic [11:0] bcnt_q, bcnt_d, rptr_q, rptr_d;
  logic [7:0]  mdr_q, mdr_d;
  logic        stat_q, stat_d;
  logic [12:0] base_q, base_d;

  logic        o_start, o_strobe, o_write, o_sv, o_er, o_ep;
  logic [31:0] o_instr, o_cmd, o_blk, o_page;
  logic [11:0] o_bcnt;
  logic [7:0]  o_mdr, o_wdata, o_sbyte;
  logic [12:0] o_addr;

  logic [31:0] ins, rown, pg;
  logic [15:0] coln, colsum;
  logic [2:0]  cc, rofs;
  logic [3:0]  need;
  logic [11:0] pgsz;
  int          on;

  assign pgsz = cfg_large ? LP_SZ : SP_SZ;
  assign cc   = cfg_large ? 3'd2 : 3'd1;
  assign rofs = abytes_q - cc;

  always_comb begin
    instr_d = instr_q; cmd_d = cmd_q; cmdnr_d = cmdnr_q; opnr_d = opnr_q;
    pgofs_d = pgofs_q; atype_d = atype_q; abytes_d = abytes_q; row_d = row_q;
    col_d = col_q; dop_d = dop_q; bcnt_d = bcnt_q; blk_d = blk_q; page_d = page_q;
    mdr_d = mdr_q; stat_d = stat_q; base_d = base_q; rptr_d = rptr_q;
    o_start = 1'b0; o_strobe = 1'b0; o_sv = 1'b0; o_er = 1'b0; o_ep = 1'b0;
    o_write = buf_write; o_addr = buf_addr; o_wdata = buf_wdata; o_sbyte = stat_byte;
    o_instr = seq_instr; o_cmd = seq_cmd; o_bcnt = seq_bcount; o_blk = seq_block;
    o_page = seq_page; o_mdr = seq_mdr;
    ins = instr_q; on = int'(opnr_q); rown = row_q; coln = col_q;
    colsum = '0; pg = '0; need = '0;
    if (req_valid) begin
      case (req_kind)
        K_CMD: begin
          if (req_data == C_PGO) begin
            ins = put_op(ins, on, OP_WB);
            on = on + 1;
          end
          cmd_d = put_cmd(cmd_q, int'(cmdnr_q), req_data);
          ins = put_op(ins, on, (cmdnr_q == 3'd0) ? OP_CW0 : ({1'b0, cmdnr_q} + 4'd4));
          on = on + 1;
          cmdnr_d = (cmdnr_q == 3'd7) ? cmdnr_q : cmdnr_q + 3'd1;
          instr_d = ins;
          opnr_d = 4'(on);
          if (req_data == C_ID) begin
            dop_d = OP_RBW; atype_d = A_ID;
          end else if (req_data == C_SPARE) begin
            dop_d = OP_RBW; atype_d = A_RC; pgofs_d = pgofs_q + 10'd512;
          end else if (req_data == C_HALF_B) begin
            dop_d = OP_RBW; atype_d = A_RC; pgofs_d = pgofs_q + 10'd256;
          end else if (req_data == C_READ) begin
            dop_d = OP_RBW; atype_d = A_RC;
          end else if (req_data == C_STAT) begin
            dop_d = OP_RS; stat_d = 1'b1;
          end else if (req_data == C_ERASE) begin
            atype_d = A_ROW;
          end else if (req_data == C_PROG) begin
            atype_d = A_RC;
          end
        end
        K_ADR: begin
          if (atype_q == A_NONE) begin
            o_ep = 1'b1;
          end else if (atype_q == A_ID) begin
            instr_d = put_op(instr_q, on, OP_UA);
            opnr_d = opnr_q + 4'd1;
            bcnt_d = 12'd5; blk_d = '0; page_d = '0; mdr_d = req_data;
            base_d = '0; rptr_d = '0;
          end else begin
            if (atype_q == A_ROW) begin
              rown = row_q | (32'(req_data) << {abytes_q[1:0], 3'b000});
              need = {1'b0, cfg_row_cycles};
            end else begin
              if (abytes_q < cc) coln = col_q | (16'(req_data) << {abytes_q[0], 3'b000});
              else rown = row_q | (32'(req_data) << {rofs[1:0], 3'b000});
              need = {1'b0, cfg_row_cycles} + {1'b0, cc};
            end
            row_d = rown; col_d = coln;
            abytes_d = (abytes_q == 3'd7) ? abytes_q : abytes_q + 3'd1;
            if (({1'b0, abytes_q} + 4'd1) >= need) begin
              rptr_d = '0;
              bcnt_d = '0;
              if (atype_q == A_RC) begin
                ins = put_op(ins, on, OP_CA);
                on = on + 1;
                colsum = coln + {6'b0, pgofs_q};
                pgofs_d = '0;
                pg = {16'b0, colsum};
                if (colsum != 16'd0) begin
                  bcnt_d = pgsz - colsum[11:0];
                  rptr_d = colsum[11:0];
                end
              end
              ins = put_op(ins, on, OP_PA);
              on = on + 1;
              if (cfg_large) begin
                blk_d = rown >> 6;
                pg = pg | ((rown << 12) & 32'h0003_F000);
                base_d = {rown[0], 12'b0};
              end else begin
                blk_d = rown >> 5;
                pg = pg | ((rown << 10) & 32'h0000_7C00);
                base_d = {rown[2:0], 10'b0};
              end
              page_d = pg;
              instr_d = ins;
              opnr_d = 4'(on);
            end
          end
        end
        K_GO: begin
          if (dop_q != 4'd0) ins = put_op(ins, on, dop_q);
          o_start = 1'b1; o_instr = ins; o_cmd = cmd_q; o_bcnt = bcnt_q;
          o_blk = blk_q; o_page = page_q; o_mdr = mdr_q;
          instr_d = '0; cmd_d = '0; cmdnr_d = '0; opnr_d = '0; pgofs_d = '0;
          atype_d = A_NONE; abytes_d = '0; row_d = '0; col_d = '0; dop_d = '0;
          bcnt_d = '0; blk_d = '0; page_d = '0; mdr_d = '0;
        end
        K_RD: begin
          if (stat_q) begin
            o_sv = 1'b1; o_sbyte = mdr_in; stat_d = 1'b0;
          end else if (rptr_q >= pgsz) begin
            o_er = 1'b1;
          end else begin
            o_strobe = 1'b1; o_write = 1'b0;
            o_addr = base_q + {1'b0, rptr_q};
            rptr_d = rptr_q + 12'd1;
          end
        end
        K_WR: begin
          if (rptr_q >= pgsz) begin
            o_er = 1'b1;
          end else begin
            o_strobe = 1'b1; o_write = 1'b1; o_wdata = req_data;
            o_addr = base_q + {1'b0, rptr_q};
            rptr_d = rptr_q + 12'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= '0; cmd_q <= '0; cmdnr_q <= '0; opnr_q <= '0; pgofs_q <= '0;
      atype_q <= A_NONE; abytes_q <= '0; row_q <= '0; col_q <= '0; dop_q <= '0;
      bcnt_q <= '0; blk_q <= '0; page_q <= '0; mdr_q <= '0; stat_q <= 1'b0;
      base_q <= '0; rptr_q <= '0;
      seq_start <= 1'b0; seq_instr <= '0; seq_cmd <= '0; seq_bcount <= '0;
      seq_block <= '0; seq_page <= '0; seq_mdr <= '0;
      buf_strobe <= 1'b0; buf_write <= 1'b0; buf_addr <= '0; buf_wdata <= '0;
      stat_valid <= 1'b0; stat_byte <= '0; err_range <= 1'b0; err_proto <= 1'b0;
    end else begin
      instr_q <= instr_d; cmd_q <= cmd_d; cmdnr_q <= cmdnr_d; opnr_q <= opnr_d;
      pgofs_q <= pgofs_d; atype_q <= atype_d; abytes_q <= abytes_d; row_q <= row_d;
      col_q <= col_d; dop_q <= dop_d; bcnt_q <= bcnt_d; blk_q <= blk_d;
      page_q <= page_d; mdr_q <= mdr_d; stat_q <= stat_d; base_q <= base_d;
      rptr_q <= rptr_d;
      seq_start <= o_start; seq_instr <= o_instr; seq_cmd <= o_cmd;
      seq_bcount <= o_bcnt; seq_block <= o_blk; seq_page <= o_page; seq_mdr <= o_mdr;
      buf_strobe <= o_strobe; buf_write <= o_write; buf_addr <= o_addr;
      buf_wdata <= o_wdata; stat_valid <= o_sv; stat_byte <= o_sbyte;
      err_range <= o_er; err_proto <= o_ep;
    end
  end
endmodule

// File: rtl/nand_uprog_xlate_chk.sv
module nand_uprog_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_large,
  input logic        req_valid,
  input logic [2:0]  req_kind,
  input logic        seq_start,
  input logic [11:0] seq_bcount,
  input logic        buf_strobe,
  input logic        buf_write,
  input logic        stat_valid,
  input logic        err_range,
  input logic        err_proto
);
  // R9
  start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> $past(req_valid && req_kind == 3'd2));
  // R11
  proto_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_proto |-> $past(req_valid && req_kind == 3'd1));
  // R10
  one_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({seq_start, buf_strobe, stat_valid, err_range, err_proto}));
  // R7
  bcount_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |-> (seq_bcount <= (cfg_large ? 12'd2112 : 12'd528)));
  // R4
  stat_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> $past(req_valid && req_kind == 3'd3));
  // R10
  wr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_strobe && buf_write) |-> $past(req_valid && req_kind == 3'd4));
endmodule

bind nand_uprog_xlate nand_uprog_xlate_chk chk_i (.*);

// File: tb/nand_uprog_xlate_tb_top.sv
`timescale 1ns/1ps
module nand_uprog_xlate_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cfg_large = 1'b1, req_valid = 1'b0;
  logic [2:0] cfg_row_cycles = 3'd3, req_kind = 3'd0;
  logic [7:0] req_data = 8'h00, mdr_in = 8'h00;
  logic seq_start, buf_strobe, buf_write, stat_valid, err_range, err_proto;
  logic [31:0] seq_instr, seq_cmd, seq_block, seq_page;
  logic [11:0] seq_bcount;
  logic [7:0] seq_mdr, buf_wdata, stat_byte;
  logic [12:0] buf_addr;

  always #2 clk = ~clk;

  nand_uprog_xlate dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural reference state
  int ops[$], cmds[$], abuf[$];
  int m_atype = 0, m_pgofs = 0, m_dop = 0, m_bcnt = 0, m_blk = 0, m_page = 0, m_mdr = 0;
  int m_stat = 0, m_base = 0, m_rptr = 0;
  int e_start = 0, e_instr = 0, e_cmd = 0, e_bcnt = 0, e_blk = 0, e_page = 0, e_mdr = 0;
  int e_strobe = 0, e_write = 0, e_addr = 0, e_wdata = 0, e_sv = 0, e_sbyte = 0, e_er = 0, e_ep = 0;

  task automatic cmp(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp("R9 seq_start", seq_start, e_start);
    cmp("R1 R2 seq_instr", seq_instr, e_instr & 32'hFFFF_FFFF);
    cmp("R1 seq_cmd", seq_cmd, e_cmd & 32'hFFFF_FFFF);
    cmp("R7 seq_bcount", seq_bcount, e_bcnt);
    cmp("R8 seq_block", seq_block, e_blk);
    cmp("R7 seq_page", seq_page, e_page);
    cmp("R3 seq_mdr", seq_mdr, e_mdr);
    cmp("R10 buf_strobe", buf_strobe, e_strobe);
    cmp("R10 buf_write", buf_write, e_write);
    cmp("R10 buf_addr", buf_addr, e_addr);
    cmp("R10 buf_wdata", buf_wdata, e_wdata);
    cmp("R4 stat_valid", stat_valid, e_sv);
    cmp("R4 stat_byte", stat_byte, e_sbyte);
    cmp("R10 err_range", err_range, e_er);
    cmp("R11 err_proto", err_proto, e_ep);
  endtask

  function automatic int pack_ops(int extra);
    int w = 0;
    int n = 0;
    foreach (ops[i]) begin
      if (n < 8) w |= ops[i] << (28 - 4 * n);
      n++;
    end
    if (extra != 0 && n < 8) w |= extra << (28 - 4 * n);
    return w;
  endfunction

  task automatic model(int kind, int d);
    int psz = cfg_large ? 2112 : 528;
    int ccnt = cfg_large ? 2 : 1;
    int need, col, row, w;
    e_start = 0; e_strobe = 0; e_sv = 0; e_er = 0; e_ep = 0;
    case (kind)
      0: begin
        if (d == 'h10) ops.push_back(8);
        ops.push_back(cmds.size() == 0 ? 12 : 4 + cmds.size());
        cmds.push_back(d);
        case (d)
          'h90: begin m_dop = 14; m_atype = 1; end
          'h50: begin m_dop = 14; m_atype = 3; m_pgofs += 512; end
          'h01: begin m_dop = 14; m_atype = 3; m_pgofs += 256; end
          'h00: begin m_dop = 14; m_atype = 3; end
          'h70: begin m_dop = 11; m_stat = 1; end
          'h60: m_atype = 2;
          'h80: m_atype = 3;
          default: ;
        endcase
      end
      1: begin
        if (m_atype == 0) e_ep = 1;
        else if (m_atype == 1) begin
          ops.push_back(3);
          m_bcnt = 5; m_blk = 0; m_page = 0; m_mdr = d; m_base = 0; m_rptr = 0;
        end else begin
          abuf.push_back(d);
          need = cfg_row_cycles + (m_atype == 3 ? ccnt : 0);
          if (abuf.size() >= need) begin
            col = 0; row = 0;
            if (m_atype == 3) begin
              for (int i = 0; i < ccnt; i++) col |= abuf[i] << (8 * i);
              for (int i = ccnt; i < abuf.size(); i++) row |= abuf[i] << (8 * (i - ccnt));
            end else
              for (int i = 0; i < abuf.size(); i++) row |= abuf[i] << (8 * i);
            m_rptr = 0; m_bcnt = 0; m_page = 0;
            if (m_atype == 3) begin
              ops.push_back(1);
              col += m_pgofs; m_pgofs = 0;
              m_page = col;
              if (col != 0) begin m_bcnt = (psz - col) & 'hFFF; m_rptr = col; end
            end
            ops.push_back(2);
            if (cfg_large) begin
              m_blk = row / 64; m_page |= (row % 64) * 4096; m_base = (row % 2) * 4096;
            end else begin
              m_blk = row / 32; m_page |= (row % 32) * 1024; m_base = (row % 8) * 1024;
            end
          end
        end
      end
      2: begin
        e_start = 1;
        e_instr = pack_ops(m_dop);
        w = 0;
        for (int i = 0; i < cmds.size() && i < 4; i++) w |= cmds[i] << (24 - 8 * i);
        e_cmd = w; e_bcnt = m_bcnt; e_blk = m_blk; e_page = m_page; e_mdr = m_mdr;
        ops.delete(); cmds.delete(); abuf.delete();
        m_atype = 0; m_pgofs = 0; m_dop = 0; m_bcnt = 0; m_blk = 0; m_page = 0; m_mdr = 0;
      end
      3: begin
        if (m_stat != 0) begin e_sv = 1; e_sbyte = mdr_in; m_stat = 0; end
        else if (m_rptr >= psz) e_er = 1;
        else begin e_strobe = 1; e_write = 0; e_addr = m_base + m_rptr; m_rptr++; end
      end
      4: begin
        if (m_rptr >= psz) e_er = 1;
        else begin e_strobe = 1; e_write = 1; e_wdata = d; e_addr = m_base + m_rptr; m_rptr++; end
      end
      default: ;
    endcase
  endtask

  task automatic step(int kind, int d, bit v = 1'b1);
    @(negedge clk);
    compare_all();
    req_valid = v; req_kind = 3'(kind); req_data = 8'(d);
    if (v) model(kind, d);
    else begin e_start = 0; e_strobe = 0; e_sv = 0; e_er = 0; e_ep = 0; end
  endtask

  task automatic idle(); step(0, 0, 1'b0); endtask
  task automatic cmd(int c); step(0, c); endtask
  task automatic adr(int a); step(1, a); endtask
  task automatic go(); step(2, 0); idle(); endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    cmp("R12 reset seq_instr", seq_instr, 0);
    cmp("R12 reset buf_addr", buf_addr, 0);
    rst_n = 1'b1;
    idle();

    // R3 read-ID
    cmd('h90); adr('h00); go();
    cmp("R3 id instr", seq_instr, 32'hC3E0_0000);
    cmp("R3 id bcount", seq_bcount, 5);
    cmp("R1 id cmd", seq_cmd, 32'h9000_0000);
    step(3, 0); step(3, 0); idle();

    // R4 status routed through data register
    cmd('h70); go();
    cmp("R4 status instr", seq_instr, 32'hCB00_0000);
    mdr_in = 8'hE0;
    step(3, 0); idle();
    cmp("R4 status byte", stat_byte, 8'hE0);
    step(3, 0); idle();
    cmp("R4 buffer after status", buf_addr, 2);

    // R5 R7 R8 large-page read
    cmd('h00); adr('h10); adr('h00); adr('h41); adr('h00); adr('h00); cmd('h30); go();
    cmp("R7 read instr", seq_instr, 32'hC125_E000);
    cmp("R1 read cmd", seq_cmd, 32'h0030_0000);
    cmp("R7 read bcount", seq_bcount, 2096);
    cmp("R8 read block", seq_block, 1);
    cmp("R7 read page", seq_page, 32'h1010);
    step(3, 0); idle();
    cmp("R8 R10 window addr", buf_addr, 4112);

    // R2 program with confirm
    cmd('h80); adr(0); adr(0); adr(2); adr(0); adr(0);
    step(4, 'hA1); step(4, 'hA2); step(4, 'hA3);
    cmd('h10); go();
    cmp("R2 prog instr", seq_instr, 32'hC128_5000);
    cmp("R2 prog cmd", seq_cmd, 32'h8010_0000);

    // R5 erase, row only
    cmd('h60); adr('h80); adr('h01); adr('h00); cmd('hD0); go();
    cmp("R5 erase instr", seq_instr, 32'hC250_0000);
    cmp("R8 erase block", seq_block, 6);

    // R11 stray address byte
    adr('h55); idle();
    cmp("R11 err_proto", err_proto, 1);
    go();
    cmp("R11 ignored instr", seq_instr, 32'h0);

    // R6 small page, second half
    cfg_large = 1'b0; cfg_row_cycles = 3'd2;
    cmd('h01); adr('h05); adr('h23); adr('h00); go();
    cmp("R6 half instr", seq_instr, 32'hC12E_0000);
    cmp("R6 half bcount", seq_bcount, 267);
    cmp("R6 half page", seq_page, 32'h0D05);
    cmp("R8 small block", seq_block, 1);

    // R6 R10 spare area then exhaustion
    cmd('h50); adr('h00); adr('h07); adr('h00); go();
    cmp("R6 spare bcount", seq_bcount, 16);
    for (int i = 0; i < 16; i++) step(3, 0);
    idle();
    cmp("R10 last spare addr", buf_addr, 7168 + 527);
    step(3, 0); idle();
    cmp("R10 read range", err_range, 1);
    step(4, 'h33); idle();
    cmp("R10 write range", err_range, 1);
    idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule